// File: doc/BRIEF.md
# PAM Level Select and Steering

This block sits between a transmit sequencer and a push-pull current driver. On every fast clock edge it samples a 4-bit transmit code and turns it into a drive command for two opposing output sides, A and B. Code zero is a forced idle: both sides are off and nothing is read from storage. Each of the fifteen non-zero codes selects its own 7-bit level register, where 127 is full scale and 0 is zero current. The half of the code space the code falls in decides which side carries that level. A runtime swap bit exchanges the two halves.

A global enable and a power-down flag both force the idle state whatever the code. Both sides come from one state register that holds exactly one of three states: `ST_OFF`, `ST_A` or `ST_B`. Overlap of the two sides therefore cannot occur. Next to the enables, the block presents the selected level and a monitoring word equal to the apodization DAC value times that level. Both read zero while idle.

Top module: `pam_steer`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `drv_a` and `drv_b` are 0 and `level` and `mag` are 0.
- R2: Code 0 sampled at a clock edge gives `drv_a`=0, `drv_b`=0, `level`=0 and `mag`=0 after that edge, even when a side was driven before.
- R3: With `swap`=0, code 1..7 (code bit 3 = 0) drives side A only and code 8..15 (bit 3 = 1) drives side B only. `level` is the register for that code, taken from `lv_flat[(n-1)*7 +: 7]` for code n.
- R4: With `swap`=1 the halves are exchanged: code 1..7 drives side B only and code 8..15 drives side A only, with the same level lookup as R3.
- R5: `drv_a` and `drv_b` are never 1 in the same cycle.
- R6: `en`=0 sampled at an edge gives both sides off after that edge, whatever the code.
- R7: `pwdn`=1 sampled at an edge gives both sides off after that edge, overriding the code and `en`.
- R8: While a side is driven, `mag` equals `dac` times `level`, with both taken at the same edge, as a 15-bit unsigned product (255 x 127 = 32385 at full scale). While idle, `mag` is 0.
- R9: A selected level register that holds 0 still drives its side (enable = 1), with `level`=0 and `mag`=0.
- R10: The outputs change only at a clock edge. They reflect the inputs sampled at the previous edge, and input changes between edges do not disturb them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast transmit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Drive enable; low forces idle |
| pwdn | input | 1 | Power-down flag; high forces idle |
| swap | input | 1 | Polarity swap of the code halves |
| dac | input | 8 | Apodization DAC value |
| code | input | 4 | Transmit code; 0 = idle |
| lv_flat | input | 105 | Fifteen 7-bit level registers, code n at bits (n-1)*7 upward |
| drv_a | output | 1 | Side A enable |
| drv_b | output | 1 | Side B enable |
| level | output | 7 | Level of the driven side, 0 when idle |
| mag | output | 15 | DAC times level, 0 when idle |

## Verification
The bench builds the block with its defaults: a 4-bit code, 7-bit levels and an 8-bit DAC. These values bring all fifteen level registers, both code halves under both swap settings, and the full-scale product of 32385 in the top of the 15-bit monitor word within reach. Level contents are chosen distinct per code, with one register holding 0 and one holding 127. A wrong lookup index, a missed swap or a dropped zero-level enable then each show up as a specific mismatch.

// File: rtl/pam_pkg.sv
package pam_pkg;
    localparam int DEF_CODE_W = 4;
    localparam int DEF_LVL_W  = 7;
    localparam int DEF_DAC_W  = 8;

    typedef enum logic [1:0] {
        ST_OFF = 2'd0,
        ST_A   = 2'd1,
        ST_B   = 2'd2
    } drv_state_e;
endpackage

// File: rtl/pam_decode.sv
module pam_decode #(
    parameter int CODE_W = pam_pkg::DEF_CODE_W
) (
    input  logic [CODE_W-1:0] code,
    input  logic              swap,
    input  logic              en,
    input  logic              pwdn,
    output logic              want_a,
    output logic              want_b
);
    logic active;
    logic upper_half;

    always_comb begin
        active     = en && !pwdn && (code != '0);
        upper_half = code[CODE_W-1];
        // lower half goes to A unless swapped; upper half to B unless swapped
        want_a     = active && (upper_half == swap);
        want_b     = active && (upper_half != swap);
    end
endmodule

// File: rtl/pam_level_mux.sv
module pam_level_mux #(
    parameter int CODE_W = pam_pkg::DEF_CODE_W,
    parameter int LVL_W  = pam_pkg::DEF_LVL_W,
    localparam int NUM_CODES = 1 << CODE_W,
    localparam int NUM_LVL   = NUM_CODES - 1
) (
    input  logic [NUM_LVL*LVL_W-1:0] lv_flat,
    input  logic [CODE_W-1:0]        idx,
    output logic [LVL_W-1:0]         sel
);
    logic [LVL_W-1:0] table_q [NUM_CODES];

    // slot 0 is the forced idle code and holds no storage
    assign table_q[0] = '0;

    for (genvar g = 0; g < NUM_LVL; g++) begin : g_slot
        assign table_q[g+1] = lv_flat[g*LVL_W +: LVL_W];
    end

    assign sel = table_q[idx];
endmodule

// File: rtl/pam_mag.sv
module pam_mag #(
    parameter int DAC_W = pam_pkg::DEF_DAC_W,
    parameter int LVL_W = pam_pkg::DEF_LVL_W,
    localparam int MAG_W = DAC_W + LVL_W
) (
    input  logic [DAC_W-1:0] dac,
    input  logic [LVL_W-1:0] lvl,
    output logic [MAG_W-1:0] prod
);
    assign prod = MAG_W'(dac) * MAG_W'(lvl);
endmodule

// File: rtl/pam_steer.sv
module pam_steer #(
    parameter int CODE_W = pam_pkg::DEF_CODE_W,
    parameter int LVL_W  = pam_pkg::DEF_LVL_W,
    parameter int DAC_W  = pam_pkg::DEF_DAC_W
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     en,
    input  logic                                     pwdn,
    input  logic                                     swap,
    input  logic [DAC_W-1:0]                         dac,
    input  logic [CODE_W-1:0]                        code,
    input  logic [((1 << CODE_W) - 1)*LVL_W-1:0]     lv_flat,
    output logic                                     drv_a,
    output logic                                     drv_b,
    output logic [LVL_W-1:0]                         level,
    output logic [DAC_W+LVL_W-1:0]                   mag
);
    import pam_pkg::*;

    localparam int MAG_W = DAC_W + LVL_W;

    drv_state_e       state_q, state_d;
    logic             want_a, want_b;
    logic [LVL_W-1:0] lvl_sel;
    logic [LVL_W-1:0] lvl_q;
    logic [DAC_W-1:0] dac_q;
    logic [MAG_W-1:0] prod;

    pam_decode #(.CODE_W(CODE_W)) u_dec (
        .code   (code),
        .swap   (swap),
        .en     (en),
        .pwdn   (pwdn),
        .want_a (want_a),
        .want_b (want_b)
    );

    pam_level_mux #(.CODE_W(CODE_W), .LVL_W(LVL_W)) u_mux (
        .lv_flat (lv_flat),
        .idx     (code),
        .sel     (lvl_sel)
    );

    pam_mag #(.DAC_W(DAC_W), .LVL_W(LVL_W)) u_mag (
        .dac  (dac_q),
        .lvl  (lvl_q),
        .prod (prod)
    );

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (want_a)      state_d = ST_A;
                else if (want_b) state_d = ST_B;
            end
            ST_A: begin
                if (want_b)       state_d = ST_B;
                else if (!want_a) state_d = ST_OFF;
            end
            ST_B: begin
                if (want_a)       state_d = ST_A;
                else if (!want_b) state_d = ST_OFF;
            end
            default: state_d = ST_OFF;
        endcase
    end

    // state and captured operands
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            lvl_q   <= '0;
            dac_q   <= '0;
        end else begin
            state_q <= state_d;
            lvl_q   <= (want_a || want_b) ? lvl_sel : '0;
            dac_q   <= dac;
        end
    end

    // outputs decoded from the single state register
    always_comb begin
        drv_a = 1'b0;
        drv_b = 1'b0;
        level = '0;
        mag   = '0;
        unique case (state_q)
            ST_OFF: ;
            ST_A: begin
                drv_a = 1'b1;
                level = lvl_q;
                mag   = prod;
            end
            ST_B: begin
                drv_b = 1'b1;
                level = lvl_q;
                mag   = prod;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pam_steer_chk.sv
module pam_steer_chk #(
    parameter int CODE_W = 4,
    parameter int LVL_W  = 7,
    parameter int MAG_W  = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              pwdn,
    input logic              swap,
    input logic [CODE_W-1:0] code,
    input logic              drv_a,
    input logic              drv_b,
    input logic [LVL_W-1:0]  level,
    input logic [MAG_W-1:0]  mag
);
    logic armed;

    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    a_r5_never_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(drv_a && drv_b));

    a_r2_idle_code: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ($past(code) == '0) |-> (!drv_a && !drv_b));

    a_r6_enable_low: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        !$past(en) |-> (!drv_a && !drv_b));

    a_r7_power_down: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(pwdn) |-> (!drv_a && !drv_b));

    a_r3_side_a: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ($past(en) && !$past(pwdn) && $past(code) != '0
         && $past(code[CODE_W-1]) == $past(swap)) |-> (drv_a && !drv_b));

    a_r4_side_b: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ($past(en) && !$past(pwdn) && $past(code) != '0
         && $past(code[CODE_W-1]) != $past(swap)) |-> (drv_b && !drv_a));

    a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!drv_a && !drv_b) |-> (mag == '0 && level == '0));
endmodule

bind pam_steer pam_steer_chk #(
    .CODE_W (CODE_W),
    .LVL_W  (LVL_W),
    .MAG_W  (DAC_W + LVL_W)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .pwdn  (pwdn),
    .swap  (swap),
    .code  (code),
    .drv_a (drv_a),
    .drv_b (drv_b),
    .level (level),
    .mag   (mag)
);

// File: tb/sim_pam_steer.sv
module sim_pam_steer;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        en, pwdn, swap;
    logic [7:0]  dac;
    logic [3:0]  code;
    logic [104:0] lv_flat;
    logic        drv_a, drv_b;
    logic [6:0]  level;
    logic [14:0] mag;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    pam_steer u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .pwdn(pwdn), .swap(swap),
        .dac(dac), .code(code), .lv_flat(lv_flat),
        .drv_a(drv_a), .drv_b(drv_b), .level(level), .mag(mag)
    );

    // {swap, code[3:0], expect_a, expect_b}
    localparam logic [6:0] TBL [12] = '{
        {1'b0, 4'd0,  1'b0, 1'b0},
        {1'b0, 4'd1,  1'b1, 1'b0},
        {1'b0, 4'd7,  1'b1, 1'b0},
        {1'b0, 4'd8,  1'b0, 1'b1},
        {1'b0, 4'd15, 1'b0, 1'b1},
        {1'b0, 4'd3,  1'b1, 1'b0},
        {1'b1, 4'd1,  1'b0, 1'b1},
        {1'b1, 4'd7,  1'b0, 1'b1},
        {1'b1, 4'd8,  1'b1, 1'b0},
        {1'b1, 4'd15, 1'b1, 1'b0},
        {1'b1, 4'd0,  1'b0, 1'b0},
        {1'b1, 4'd12, 1'b1, 1'b0}
    };

    function automatic logic [6:0] lv_of(input int n);
        if (n == 0)  return 7'd0;
        if (n == 5)  return 7'd0;
        if (n == 15) return 7'd127;
        return 7'(n * 8 + 3);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] c, input logic s, input logic e, input logic p);
        @(negedge clk);
        code = c; swap = s; en = e; pwdn = p;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; en = 1'b1; pwdn = 1'b0; swap = 1'b0;
        dac = 8'd200; code = 4'd9;
        for (int n = 1; n < 16; n++) lv_flat[(n-1)*7 +: 7] = lv_of(n);
        repeat (3) @(negedge clk);
        // R1: outputs idle during reset despite an active code
        chk("R1 drv_a", drv_a, 0);
        chk("R1 drv_b", drv_b, 0);
        chk("R1 mag", mag, 0);
        code = 4'd0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 level after release", level, 0);

        // table walk: R3, R4, R2, R5, R8
        for (int i = 0; i < 12; i++) begin
            logic [3:0] c;
            logic       s, ea, eb;
            int         el;
            {s, c, ea, eb} = TBL[i];
            drive(c, s, 1'b1, 1'b0);
            el = (ea || eb) ? int'(lv_of(int'(c))) : 0;
            chk(s ? "R4 drv_a" : "R3 drv_a", drv_a, ea);
            chk(s ? "R4 drv_b" : "R3 drv_b", drv_b, eb);
            chk(s ? "R4 level" : "R3 level", level, el);
            chk("R8 mag", mag, el * 200);
            chk("R5 exclusive", drv_a & drv_b, 0);
        end

        // R2: idle code right after a driven side
        drive(4'd2, 1'b0, 1'b1, 1'b0);
        chk("R3 code2 on A", drv_a, 1);
        drive(4'd0, 1'b0, 1'b1, 1'b0);
        chk("R2 idle a", drv_a, 0);
        chk("R2 idle b", drv_b, 0);
        chk("R2 idle mag", mag, 0);

        // R6: enable low
        drive(4'd3, 1'b0, 1'b0, 1'b0);
        chk("R6 a off", drv_a, 0);
        chk("R6 b off", drv_b, 0);

        // R7: power-down overrides code and enable
        drive(4'd9, 1'b0, 1'b1, 1'b1);
        chk("R7 a off", drv_a, 0);
        chk("R7 b off", drv_b, 0);
        chk("R7 mag", mag, 0);

        // R9: zero level keeps the enable
        drive(4'd5, 1'b0, 1'b1, 1'b0);
        chk("R9 enable held", drv_a, 1);
        chk("R9 level zero", level, 0);
        chk("R9 mag zero", mag, 0);
        drive(4'd13, 1'b1, 1'b1, 1'b0);
        chk("R9 code13 swapped to A", drv_a, 1);

        // R8: full scale
        @(negedge clk);
        dac = 8'd255;
        drive(4'd15, 1'b0, 1'b1, 1'b0);
        chk("R8 full scale side", drv_b, 1);
        chk("R8 full scale mag", mag, 32385);

        // R10: changes between edges do not move the outputs
        @(negedge clk);
        code = 4'd1; dac = 8'd3; swap = 1'b1;
        #1;
        chk("R10 hold b", drv_b, 1);
        chk("R10 hold mag", mag, 32385);
        @(negedge clk);
        chk("R10 after edge b", drv_b, 1);
        chk("R10 after edge level", level, int'(lv_of(1)));
        chk("R10 after edge mag", mag, 3 * int'(lv_of(1)));

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule